// File: doc/BRIEF.md
# Polled/Interrupt Character I/O Port

This block places a keyboard-style input channel and a display-style output channel behind four 8-bit registers on a shared processor bus. A keyboard-side source delivers one byte per strobe. The processor learns that a byte is waiting either by polling a status flag or by taking an interrupt. Reading the byte consumes it. Output bytes written by the processor go to a display-side sink with a one-cycle load pulse. The sink reports that it can take another byte with a done pulse.

Four consecutive word addresses, starting at a parameterised base, select the registers. Address bits [1:0] pick the register:

- 0: received byte.
- 1: transmit byte.
- 2: flags.
- 3: control.

Reads return data in the same cycle, so `bus_rdata` is combinational. The side effects of a read (flags being consumed) take effect at the next clock edge. The interrupt line is gated by one control bit. When that bit is set, the line follows the two channel-ready flags.

Top module: `chario_port`

## Requirements
- R1: The port responds only when `bus_addr[ADDR_W-1:2]` equals `BASE_ADDR[ADDR_W-1:2]`. On any other address, `bus_hit` is 0 and `bus_rdata` is 0. A write to any other address changes no register.
- R2: After reset the following hold:
  - the received byte, the transmit byte and the control register read 0x00;
  - the flags register reads 0x02;
  - `irq` and `disp_load` are 0.
- R3: A `kbd_stb` pulse captures `kbd_byte` into the received-byte register (offset 0) and sets flag bit 0 (input ready).
- R4: Reading offset 0 clears flag bit 0 at the next edge. If `kbd_stb` arrives in that same cycle, the flag stays set and no overrun is recorded.
- R5: Overrun is recorded in flag bit 3 (sticky):
  - A strobe while flag bit 0 is already set, with no read of offset 0 in that cycle, replaces the byte and sets flag bit 3.
  - A read of offset 2 clears bit 3, but a new overrun in that same cycle wins.
- R6: A write to offset 1 does three things on the next edge:
  - it stores the byte and presents it on `disp_data`;
  - it pulses `disp_load` high for exactly one cycle;
  - it clears flag bit 1 (output ready).
- R7: A `disp_done` pulse sets flag bit 1. When a write to offset 1 falls in the same cycle, the write wins and the flag is left clear.
- R8: The control register (offset 3) stores all 8 written bits and reads them back. Bit 2 is the interrupt enable.
- R9: When control bit 2 is 1, `irq` and flag bit 2 equal (flag bit 0 OR flag bit 1).
- R10: When control bit 2 is 0, `irq` and flag bit 2 are 0 whatever the other flags are.
- R11: Writes to offsets 0 and 2 are ignored. Neither the received byte nor any flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address from the processor |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero unless the port is addressed and read |
| bus_hit | output | 1 | Address falls in this port's window |
| kbd_stb | input | 1 | One-cycle pulse: new input byte present |
| kbd_byte | input | 8 | Input byte from the keyboard side |
| disp_data | output | 8 | Byte held for the display side |
| disp_load | output | 1 | One-cycle pulse: new byte on disp_data |
| disp_done | input | 1 | One-cycle pulse: display accepts another byte |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions assume the following about the inputs:
- `bus_rd` and `bus_wr` are never high in the same cycle.
- `kbd_stb` and `disp_done` are single-cycle pulses that are meaningful only outside reset.

The stimulus tasks drive exactly one bus operation per task call and release every strobe one cycle later. Collisions are produced only on purpose, through a dedicated task that raises a read and a strobe together. Collisions covered are a strobe against an input read, a done pulse against an output write, and an overrun against a flags read.

// File: rtl/chario_pkg.sv
package chario_pkg;

    localparam int BYTE_W = 8;

    // register selected by the two low word-address bits
    typedef enum logic [1:0] {
        SEL_RXB  = 2'd0,
        SEL_TXB  = 2'd1,
        SEL_FLAG = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    // flag register layout, msb first
    typedef struct packed {
        logic [3:0] spare;
        logic       overrun;   // bit 3
        logic       irq_seen;  // bit 2
        logic       tx_ready;  // bit 1
        logic       rx_ready;  // bit 0
    } flags_t;

    localparam int CTRL_IE_BIT = 2;

    // decoded bus strobes
    typedef struct packed {
        logic rd_rxb;
        logic rd_flag;
        logic wr_txb;
        logic wr_ctrl;
    } bus_strb_t;

    function automatic logic [BYTE_W-1:0] read_mux(
        input logic              hit,
        input logic              rd,
        input reg_sel_e          sel,
        input logic [BYTE_W-1:0] rxb,
        input logic [BYTE_W-1:0] txb,
        input flags_t            flg,
        input logic [BYTE_W-1:0] ctl
    );
        logic [BYTE_W-1:0] v;
        unique case (sel)
            SEL_RXB:  v = rxb;
            SEL_TXB:  v = txb;
            SEL_FLAG: v = flg;
            default:  v = ctl;
        endcase
        return (hit && rd) ? v : '0;
    endfunction

endpackage

// File: rtl/chario_decode.sv
module chario_decode
    import chario_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0040
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              hit,
    output reg_sel_e          sel,
    output bus_strb_t         strb
);
    localparam int TAG_W = ADDR_W - 2;
    localparam logic [TAG_W-1:0] BASE_TAG = BASE_ADDR[ADDR_W-1:2];

    always_comb begin
        hit          = (addr[ADDR_W-1:2] == BASE_TAG);
        sel          = reg_sel_e'(addr[1:0]);
        strb.rd_rxb  = hit && rd && (sel == SEL_RXB);
        strb.rd_flag = hit && rd && (sel == SEL_FLAG);
        strb.wr_txb  = hit && wr && (sel == SEL_TXB);
        strb.wr_ctrl = hit && wr && (sel == SEL_CTRL);
    end
endmodule

// File: rtl/chario_rx.sv
module chario_rx
    import chario_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              rd_rxb,
    input  logic              rd_flag,
    output logic [BYTE_W-1:0] rxb,
    output logic              rx_ready,
    output logic              overrun
);
    logic lost;
    assign lost = stb && rx_ready && !rd_rxb;

    always_ff @(posedge clk) begin
        if (rst) begin
            rxb      <= '0;
            rx_ready <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            if (stb) begin
                rxb      <= byte_in;
                rx_ready <= 1'b1;
            end else if (rd_rxb) begin
                rx_ready <= 1'b0;
            end
            if (lost)         overrun <= 1'b1;
            else if (rd_flag) overrun <= 1'b0;
        end
    end

    assert_rd_consumes_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_rxb && !stb) |=> !rx_ready);
    assert_strobe_sets_R3: assert property (@(posedge clk) disable iff (rst)
        stb |=> (rx_ready && rxb == $past(byte_in)));
    assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (overrun && !rd_flag) |=> overrun);
    assert_overrun_set_R5: assert property (@(posedge clk) disable iff (rst)
        (stb && rx_ready && !rd_rxb) |=> overrun);
endmodule

// File: rtl/chario_tx.sv
module chario_tx
    import chario_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_txb,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              done,
    output logic [BYTE_W-1:0] txb,
    output logic              tx_ready,
    output logic              load
);
    always_ff @(posedge clk) begin
        if (rst) begin
            txb      <= '0;
            tx_ready <= 1'b1;
            load     <= 1'b0;
        end else begin
            load <= wr_txb;
            if (wr_txb) begin
                txb      <= wdata;
                tx_ready <= 1'b0;
            end else if (done) begin
                tx_ready <= 1'b1;
            end
        end
    end

    assert_write_hands_off_R6: assert property (@(posedge clk) disable iff (rst)
        wr_txb |=> (load && !tx_ready && txb == $past(wdata)));
    assert_load_single_R6: assert property (@(posedge clk) disable iff (rst)
        load |=> !load || $past(wr_txb));
    assert_done_rearms_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !wr_txb) |=> tx_ready);
endmodule

// File: rtl/chario_irq.sv
module chario_irq
    import chario_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rx_ready,
    input  logic              tx_ready,
    input  logic              overrun,
    output logic [BYTE_W-1:0] ctrl,
    output flags_t            flags,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (rst)          ctrl <= '0;
        else if (wr_ctrl) ctrl <= wdata;
    end

    always_comb begin
        irq            = ctrl[CTRL_IE_BIT] && (rx_ready || tx_ready);
        flags.spare    = '0;
        flags.overrun  = overrun;
        flags.irq_seen = irq;
        flags.tx_ready = tx_ready;
        flags.rx_ready = rx_ready;
    end

    assert_ctrl_holds_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(ctrl));
endmodule

// File: rtl/chario_port.sv
module chario_port
    import chario_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0040
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              bus_hit,
    input  logic              kbd_stb,
    input  logic [BYTE_W-1:0] kbd_byte,
    output logic [BYTE_W-1:0] disp_data,
    output logic              disp_load,
    input  logic              disp_done,
    output logic              irq
);
    reg_sel_e          sel;
    bus_strb_t         strb;
    logic [BYTE_W-1:0] rxb;
    logic [BYTE_W-1:0] ctrl;
    logic              rx_ready;
    logic              tx_ready;
    logic              overrun;
    flags_t            flags;

    chario_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
        .hit(bus_hit), .sel(sel), .strb(strb)
    );

    chario_rx u_rx (
        .clk(clk), .rst(rst), .stb(kbd_stb), .byte_in(kbd_byte),
        .rd_rxb(strb.rd_rxb), .rd_flag(strb.rd_flag),
        .rxb(rxb), .rx_ready(rx_ready), .overrun(overrun)
    );

    chario_tx u_tx (
        .clk(clk), .rst(rst), .wr_txb(strb.wr_txb), .wdata(bus_wdata),
        .done(disp_done), .txb(disp_data), .tx_ready(tx_ready),
        .load(disp_load)
    );

    chario_irq u_irq (
        .clk(clk), .rst(rst), .wr_ctrl(strb.wr_ctrl), .wdata(bus_wdata),
        .rx_ready(rx_ready), .tx_ready(tx_ready), .overrun(overrun),
        .ctrl(ctrl), .flags(flags), .irq(irq)
    );

    assign bus_rdata = read_mux(bus_hit, bus_rd, sel, rxb, disp_data, flags, ctrl);

    assert_miss_no_write_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_hit && !kbd_stb && !disp_done && !$past(bus_wr))
        |=> ($stable(ctrl) && $stable(disp_data) && $stable(rxb)));
    assert_reset_state_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tx_ready && !rx_ready && !overrun && !disp_load));
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
        (!ctrl[CTRL_IE_BIT]) |-> !irq);
    assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl[CTRL_IE_BIT] && disp_load) |-> (irq == rx_ready));
    assert_no_rd_wr_R1: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));
endmodule

// File: tb/chario_port_tb.sv
module chario_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] BASE = 16'h0040;
    localparam logic [15:0] A_RXB  = BASE + 16'd0;
    localparam logic [15:0] A_TXB  = BASE + 16'd1;
    localparam logic [15:0] A_FLAG = BASE + 16'd2;
    localparam logic [15:0] A_CTRL = BASE + 16'd3;
    localparam logic [15:0] A_MISS = BASE + 16'd7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_hit;
    logic        kbd_stb = 1'b0;
    logic [7:0]  kbd_byte = '0;
    logic [7:0]  disp_data;
    logic        disp_load;
    logic        disp_done = 1'b0;
    logic        irq;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    logic [7:0] exp_q[$];
    logic       hit_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    chario_port #(.ADDR_W(16), .BASE_ADDR(BASE)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_hit(bus_hit), .kbd_stb(kbd_stb), .kbd_byte(kbd_byte),
        .disp_data(disp_data), .disp_load(disp_load),
        .disp_done(disp_done), .irq(irq)
    );

    // monitor: compares each read against the scoreboard head
    always @(negedge clk) begin
        if (bus_rd && exp_q.size() > 0) begin
            logic [7:0] e;
            logic       h;
            string      t;
            e = exp_q.pop_front();
            h = hit_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if (bus_rdata !== e || bus_hit !== h) begin
                n_bad++;
                $display("FAIL %s: rdata=%02h hit=%0b expected rdata=%02h hit=%0b",
                         t, bus_rdata, bus_hit, e, h);
            end
        end
    end

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] e, input logic h, input string tag);
        exp_q.push_back(e); hit_q.push_back(h); tag_q.push_back(tag);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic with_done);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; disp_done = with_done;
        @(posedge clk); #1;
        bus_wr = 1'b0; disp_done = 1'b0;
    endtask

    task automatic key(input logic [7:0] b);
        @(posedge clk); #1;
        kbd_byte = b; kbd_stb = 1'b1;
        @(posedge clk); #1;
        kbd_stb = 1'b0;
    endtask

    task automatic done_pulse();
        @(posedge clk); #1;
        disp_done = 1'b1;
        @(posedge clk); #1;
        disp_done = 1'b0;
    endtask

    // read of address a together with a keyboard strobe in one cycle
    task automatic rd_with_key(input logic [15:0] a, input logic [7:0] e, input logic [7:0] b,
                               input string tag);
        exp_q.push_back(e); hit_q.push_back(1'b1); tag_q.push_back(tag);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1; kbd_byte = b; kbd_stb = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0; kbd_stb = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R2 reset values
        check({7'd0, irq}, 8'h00, "R2 irq");
        check({7'd0, disp_load}, 8'h00, "R2 disp_load");
        rd(A_FLAG, 8'h02, 1'b1, "R2 flags");
        rd(A_RXB,  8'h00, 1'b1, "R2 rxb");
        rd(A_TXB,  8'h00, 1'b1, "R2 txb");
        rd(A_CTRL, 8'h00, 1'b1, "R2 ctrl");

        // R1 decode
        wr(A_MISS, 8'hFF, 1'b0);
        rd(A_CTRL, 8'h00, 1'b1, "R1 miss write ignored");
        check(disp_data, 8'h00, "R1 miss write no txb");
        rd(A_MISS, 8'h00, 1'b0, "R1 miss read");
        rd(16'h0000, 8'h00, 1'b0, "R1 miss low");

        // R3/R4 basic receive
        key(8'h41);
        rd(A_FLAG, 8'h03, 1'b1, "R3 rx ready set");
        rd(A_RXB,  8'h41, 1'b1, "R3 byte captured");
        rd(A_FLAG, 8'h02, 1'b1, "R4 read consumes");

        // R5 overrun
        key(8'h11);
        key(8'h22);
        rd(A_FLAG, 8'h0B, 1'b1, "R5 overrun set");
        rd(A_FLAG, 8'h03, 1'b1, "R5 overrun cleared by flag read");
        rd(A_RXB,  8'h22, 1'b1, "R5 newest byte kept");
        rd(A_FLAG, 8'h02, 1'b1, "R4 consumed after overrun");

        // R5 new overrun wins against flag read
        key(8'h01);
        rd_with_key(A_FLAG, 8'h03, 8'h02, "R5 flag read during overrun");
        rd(A_FLAG, 8'h0B, 1'b1, "R5 overrun set wins");
        rd(A_RXB,  8'h02, 1'b1, "R5 byte after collision");

        // R4 strobe during data read
        key(8'h33);
        rd_with_key(A_RXB, 8'h33, 8'h44, "R4 read old byte in collision");
        rd(A_FLAG, 8'h03, 1'b1, "R4 strobe keeps ready no overrun");
        rd(A_RXB,  8'h44, 1'b1, "R4 new byte after collision");

        // R6 transmit
        wr(A_TXB, 8'h5A, 1'b0);
        check({7'd0, disp_load}, 8'h01, "R6 load pulse");
        check(disp_data, 8'h5A, "R6 disp_data");
        @(posedge clk); #1;
        check({7'd0, disp_load}, 8'h00, "R6 load single cycle");
        rd(A_FLAG, 8'h00, 1'b1, "R6 tx ready cleared");
        rd(A_TXB,  8'h5A, 1'b1, "R6 txb readback");
        done_pulse();
        rd(A_FLAG, 8'h02, 1'b1, "R7 done sets ready");

        // R7 write wins over done
        wr(A_TXB, 8'hC3, 1'b1);
        rd(A_FLAG, 8'h00, 1'b1, "R7 write wins over done");
        done_pulse();
        rd(A_FLAG, 8'h02, 1'b1, "R7 ready after later done");

        // R11 writes to offsets 0 and 2 ignored
        key(8'h55);
        key(8'h66);
        wr(A_RXB, 8'h77, 1'b0);
        wr(A_FLAG, 8'h00, 1'b0);
        rd(A_FLAG, 8'h0B, 1'b1, "R11 flag write ignored");
        rd(A_RXB,  8'h66, 1'b1, "R11 rxb write ignored");
        rd(A_FLAG, 8'h02, 1'b1, "R11 flags after drain");

        // R8/R9 enable
        wr(A_CTRL, 8'h04, 1'b0);
        rd(A_CTRL, 8'h04, 1'b1, "R8 ctrl readback");
        check({7'd0, irq}, 8'h01, "R9 irq from tx ready");
        rd(A_FLAG, 8'h06, 1'b1, "R9 flag bit 2");
        wr(A_TXB, 8'h10, 1'b0);
        check({7'd0, irq}, 8'h00, "R9 irq low no flags");
        key(8'h66);
        check({7'd0, irq}, 8'h01, "R9 irq from rx ready");
        rd(A_FLAG, 8'h05, 1'b1, "R9 flags rx+irq");
        rd(A_RXB, 8'h66, 1'b1, "R9 drain");
        check({7'd0, irq}, 8'h00, "R9 irq drops after read");
        done_pulse();
        check({7'd0, irq}, 8'h01, "R9 irq after done");

        // R10 disable
        wr(A_CTRL, 8'hFB, 1'b0);
        rd(A_CTRL, 8'hFB, 1'b1, "R8 all bits stored");
        check({7'd0, irq}, 8'h00, "R10 irq masked tx");
        key(8'h01);
        check({7'd0, irq}, 8'h00, "R10 irq masked both");
        rd(A_FLAG, 8'h03, 1'b1, "R10 flag bit 2 low");

        repeat (2) @(posedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule